// File: doc/BRIEF.md
# Command Block Fetch Engine

This block sits on the target side of a serial-bus storage link. It pulls operation request blocks (ORBs) out of an initiator's memory without help from the host. One management agent (index 0) and a set of command agents (indices 1 and up, four by default) each keep a pointer register. An initiator writes an ORB address into an agent's register, and that agent is then queued for a fetch. The engine issues one block read for the whole 32-byte ORB and collects the eight returned quadlets. It then presents the complete ORB to the host and holds it until the host acknowledges it. The host never sees the individual request or response packets.

A command agent follows the next-ORB link in the first two quadlets of each fetched ORB. Once the host acknowledges the current ORB, the agent queues the linked ORB automatically. It stops when the link's null flag is set. The management agent never chains. Queued agents are served in round-robin order, and only one read request is ever outstanding. An error response kills the agent that issued the fetch, and only a host reset of that agent revives it.

Top module: `orb_fetch_engine`

## Requirements
- R1: After reset, `rdReqValid` and `orbReady` are low and every agent is idle.
- R2: A pointer write to an idle agent produces exactly one read request. The request carries that agent's index, the written 48-bit address, and a length of 32 bytes in `rdReqBytes`. The request is held steady until `rdReqReady`.
- R3: `orbReady` rises only after the eighth good response quadlet. `orbData[32*i+31:32*i]` holds the i-th returned quadlet, and `orbAgent` names the agent that fetched it.
- R4: While an ORB is presented, `orbReady`, `orbAgent` and `orbData` hold until `orbAck`. No new read request is issued while a fetch or a presentation is in progress.
- R5: After a command agent's ORB is acknowledged, the agent fetches the next ORB at {quadlet0[15:0], quadlet1} when quadlet 0 bit 31 is clear. No chained request appears before the acknowledge.
- R6: When quadlet 0 bit 31 of a command agent's ORB is set, the agent goes idle after the acknowledge. No further request follows, and a new pointer write is accepted.
- R7: The management agent (index 0) goes idle after its acknowledge whatever its next-ORB field holds.
- R8: Pending agents are granted in round-robin order, starting after the agent granted last (agent 0 first after reset).
- R9: An error response (`rspValid` with `rspError`) during a fetch makes that agent dead. Pointer writes to a dead agent are ignored until its `agentRst` bit is pulsed. Other agents keep working.
- R10: A pointer write to an agent that is pending or busy is ignored. The address already queued is the one fetched.
- R11: A pointer write naming an agent index at or beyond the number of agents has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ptrWrValid | input | 1 | Initiator wrote an agent's ORB pointer |
| ptrWrAgent | input | AGENT_W | Agent index of the write (0 = management) |
| ptrWrAddr | input | ADDR_W | ORB address written |
| agentRst | input | NUM_AGENTS | Host reset, one bit per agent |
| rdReqValid | output | 1 | Block read request pending |
| rdReqReady | input | 1 | Request accepted by the packet layer |
| rdReqAgent | output | AGENT_W | Agent owning the request |
| rdReqAddr | output | ADDR_W | Address of the ORB to read |
| rdReqBytes | output | 16 | Read length in bytes |
| rspValid | input | 1 | Response beat present |
| rspError | input | 1 | Response beat reports an error |
| rspData | input | 32 | Response quadlet |
| orbReady | output | 1 | Complete ORB presented to host |
| orbAgent | output | AGENT_W | Agent that fetched the presented ORB |
| orbData | output | ORB_QUADS*32 | Presented ORB, quadlet 0 in the low bits |
| orbAck | input | 1 | Host has consumed the presented ORB |

## Verification
Every command agent is driven through chains of length one, two and three, so fetching a linked ORB is distinguished from stopping on the null flag at each possible depth. A management ORB carrying a non-null link separates the management agent's no-chain rule from the command agents' behaviour. Pointers are written in a scrambled agent order to expose the round-robin grant order. Pointers are also written while an agent is pending or busy, or while it is dead, or with an out-of-range index; each time the bench checks the request stream for silence or for the original address. An error response followed by an agent reset shows that the dead state is contained to one agent and can be cleared.

// File: rtl/orb_fetch_pkg.sv
package orb_fetch_pkg;

  typedef enum logic [1:0] {
    AG_IDLE,
    AG_PEND,
    AG_BUSY,
    AG_DEAD
  } agentState_e;

  typedef enum logic [1:0] {
    EN_IDLE,
    EN_REQ,
    EN_RX,
    EN_SHOW
  } engState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ptrLoad;
    logic chainLoad;
    logic quadCapture;
    logic countClear;
  } dpCtl_t;

endpackage

// File: rtl/orb_fetch_dp.sv
module orb_fetch_dp
  import orb_fetch_pkg::*;
#(
  parameter int NUM_AGENTS = 5,
  parameter int AGENT_W    = 3,
  parameter int ADDR_W     = 48,
  parameter int ORB_QUADS  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpCtl_t                    ctl,
  input  logic [AGENT_W-1:0]        ptrAgent,
  input  logic [ADDR_W-1:0]         ptrAddr,
  input  logic [AGENT_W-1:0]        curAgent,
  input  logic [31:0]               rspData,
  output logic [ADDR_W-1:0]         reqAddr,
  output logic                      lastQuad,
  output logic                      nextNull,
  output logic [ORB_QUADS*32-1:0]   orbFlat
);

  localparam int CNT_W = $clog2(ORB_QUADS);
  localparam int HI_W  = ADDR_W - 32;

  logic [ADDR_W-1:0] addrReg [NUM_AGENTS];
  logic [31:0]       orbBuf  [ORB_QUADS];
  logic [CNT_W-1:0]  quadCnt;
  logic [ADDR_W-1:0] linkAddr;

  assign linkAddr = {orbBuf[0][HI_W-1:0], orbBuf[1]};
  assign nextNull = orbBuf[0][31];
  assign lastQuad = (quadCnt == CNT_W'(ORB_QUADS - 1));

  // one pointer register per agent
  for (genvar g = 0; g < NUM_AGENTS; g++) begin : gAgentAddr
    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrReg[g] <= '0;
      end else if (ctl.ptrLoad && ptrAgent == AGENT_W'(g)) begin
        addrReg[g] <= ptrAddr;
      end else if (ctl.chainLoad && curAgent == AGENT_W'(g)) begin
        addrReg[g] <= linkAddr;
      end
    end
  end

  always_comb begin
    reqAddr = '0;
    for (int g = 0; g < NUM_AGENTS; g++) begin
      if (curAgent == AGENT_W'(g)) reqAddr = addrReg[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quadCnt <= '0;
    end else if (ctl.countClear) begin
      quadCnt <= '0;
    end else if (ctl.quadCapture && !lastQuad) begin
      quadCnt <= quadCnt + 1'b1;
    end
  end

  // ORB staging buffer, one quadlet slot each
  for (genvar q = 0; q < ORB_QUADS; q++) begin : gOrbSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        orbBuf[q] <= '0;
      end else if (ctl.quadCapture && quadCnt == CNT_W'(q)) begin
        orbBuf[q] <= rspData;
      end
    end
    assign orbFlat[32*q +: 32] = orbBuf[q];
  end

endmodule

// File: rtl/orb_fetch_ctrl.sv
module orb_fetch_ctrl
  import orb_fetch_pkg::*;
#(
  parameter int NUM_AGENTS = 5,
  parameter int AGENT_W    = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ptrWrValid,
  input  logic [AGENT_W-1:0]    ptrWrAgent,
  input  logic [NUM_AGENTS-1:0] agentRst,
  input  logic                  rdReqReady,
  input  logic                  rspValid,
  input  logic                  rspError,
  input  logic                  orbAck,
  input  logic                  lastQuad,
  input  logic                  nextNull,
  output dpCtl_t                ctl,
  output logic [AGENT_W-1:0]    curAgent,
  output logic                  rdReqValid,
  output logic                  orbReady
);

  agentState_e agentSt  [NUM_AGENTS];
  agentState_e agentNxt [NUM_AGENTS];
  engState_e   engSt;
  logic [AGENT_W-1:0] lastGrant;
  logic [AGENT_W-1:0] grantIdx;
  logic grantFound;
  logic launch;
  logic rxErr;
  logic ackNow;
  logic ptrAccept;
  logic curIsMgmt;

  // round-robin search starting after the last grant
  always_comb begin
    int t;
    grantFound = 1'b0;
    grantIdx   = '0;
    for (int k = 1; k <= NUM_AGENTS; k++) begin
      t = int'(lastGrant) + k;
      if (t >= NUM_AGENTS) t = t - NUM_AGENTS;
      if (!grantFound && agentSt[t] == AG_PEND) begin
        grantFound = 1'b1;
        grantIdx   = AGENT_W'(t);
      end
    end
  end

  assign launch    = (engSt == EN_IDLE) && grantFound;
  assign rxErr     = (engSt == EN_RX) && rspValid && rspError;
  assign ackNow    = (engSt == EN_SHOW) && orbAck;
  assign curIsMgmt = (curAgent == '0);

  always_comb begin
    ptrAccept = 1'b0;
    for (int g = 0; g < NUM_AGENTS; g++) begin
      agentNxt[g] = agentSt[g];
      if (ptrWrValid && ptrWrAgent == AGENT_W'(g) && agentSt[g] == AG_IDLE) begin
        agentNxt[g] = AG_PEND;
        ptrAccept   = 1'b1;
      end
      if (launch && grantIdx == AGENT_W'(g)) agentNxt[g] = AG_BUSY;
      if (rxErr && curAgent == AGENT_W'(g)) agentNxt[g] = AG_DEAD;
      if (ackNow && curAgent == AGENT_W'(g)) begin
        agentNxt[g] = (g == 0 || nextNull) ? AG_IDLE : AG_PEND;
      end
      if (agentRst[g] && agentSt[g] != AG_BUSY) agentNxt[g] = AG_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    for (int g = 0; g < NUM_AGENTS; g++) begin
      if (!rstN) agentSt[g] <= AG_IDLE;
      else       agentSt[g] <= agentNxt[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      engSt     <= EN_IDLE;
      curAgent  <= '0;
      lastGrant <= AGENT_W'(NUM_AGENTS - 1);
    end else begin
      unique case (engSt)
        EN_IDLE: begin
          if (launch) begin
            engSt     <= EN_REQ;
            curAgent  <= grantIdx;
            lastGrant <= grantIdx;
          end
        end
        EN_REQ: if (rdReqReady) engSt <= EN_RX;
        EN_RX: begin
          if (rspValid) begin
            if (rspError)      engSt <= EN_IDLE;
            else if (lastQuad) engSt <= EN_SHOW;
          end
        end
        EN_SHOW: if (orbAck) engSt <= EN_IDLE;
        default: engSt <= EN_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.ptrLoad     = ptrAccept;
    ctl.chainLoad   = ackNow && !curIsMgmt && !nextNull;
    ctl.quadCapture = (engSt == EN_RX) && rspValid && !rspError;
    ctl.countClear  = launch;
  end

  assign rdReqValid = (engSt == EN_REQ);
  assign orbReady   = (engSt == EN_SHOW);

endmodule

// File: rtl/orb_fetch_engine.sv
module orb_fetch_engine
  import orb_fetch_pkg::*;
#(
  parameter  int NUM_CMD_AGENTS = 4,
  parameter  int ADDR_W         = 48,
  parameter  int ORB_QUADS      = 8,
  localparam int NUM_AGENTS     = NUM_CMD_AGENTS + 1,
  localparam int AGENT_W        = $clog2(NUM_AGENTS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ptrWrValid,
  input  logic [AGENT_W-1:0]      ptrWrAgent,
  input  logic [ADDR_W-1:0]       ptrWrAddr,
  input  logic [NUM_AGENTS-1:0]   agentRst,
  output logic                    rdReqValid,
  input  logic                    rdReqReady,
  output logic [AGENT_W-1:0]      rdReqAgent,
  output logic [ADDR_W-1:0]       rdReqAddr,
  output logic [15:0]             rdReqBytes,
  input  logic                    rspValid,
  input  logic                    rspError,
  input  logic [31:0]             rspData,
  output logic                    orbReady,
  output logic [AGENT_W-1:0]      orbAgent,
  output logic [ORB_QUADS*32-1:0] orbData,
  input  logic                    orbAck
);

  dpCtl_t             ctl;
  logic [AGENT_W-1:0] curAgent;
  logic               lastQuad;
  logic               nextNull;

  orb_fetch_ctrl #(
    .NUM_AGENTS(NUM_AGENTS),
    .AGENT_W   (AGENT_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ptrWrValid(ptrWrValid),
    .ptrWrAgent(ptrWrAgent),
    .agentRst  (agentRst),
    .rdReqReady(rdReqReady),
    .rspValid  (rspValid),
    .rspError  (rspError),
    .orbAck    (orbAck),
    .lastQuad  (lastQuad),
    .nextNull  (nextNull),
    .ctl       (ctl),
    .curAgent  (curAgent),
    .rdReqValid(rdReqValid),
    .orbReady  (orbReady)
  );

  orb_fetch_dp #(
    .NUM_AGENTS(NUM_AGENTS),
    .AGENT_W   (AGENT_W),
    .ADDR_W    (ADDR_W),
    .ORB_QUADS (ORB_QUADS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .ptrAgent(ptrWrAgent),
    .ptrAddr (ptrWrAddr),
    .curAgent(curAgent),
    .rspData (rspData),
    .reqAddr (rdReqAddr),
    .lastQuad(lastQuad),
    .nextNull(nextNull),
    .orbFlat (orbData)
  );

  assign rdReqAgent = curAgent;
  assign orbAgent   = curAgent;
  assign rdReqBytes = 16'(ORB_QUADS * 4);

endmodule

// File: rtl/orb_fetch_chk.sv
module orb_fetch_chk #(
  parameter int NUM_AGENTS = 5,
  parameter int AGENT_W    = 3,
  parameter int ADDR_W     = 48,
  parameter int ORB_QUADS  = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    rdReqValid,
  input logic                    rdReqReady,
  input logic [AGENT_W-1:0]      rdReqAgent,
  input logic [ADDR_W-1:0]       rdReqAddr,
  input logic                    rspValid,
  input logic                    rspError,
  input logic                    orbReady,
  input logic [AGENT_W-1:0]      orbAgent,
  input logic [ORB_QUADS*32-1:0] orbData,
  input logic                    orbAck
);

  // good beats seen since the last accepted request
  logic [7:0] beats;
  always_ff @(posedge clk) begin
    if (!rstN)                          beats <= '0;
    else if (rdReqValid && rdReqReady)  beats <= '0;
    else if (rspValid && !rspError)     beats <= beats + 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!rdReqValid && !orbReady));

  a_r2_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (rdReqValid && !rdReqReady) |=> (rdReqValid && $stable(rdReqAddr) && $stable(rdReqAgent)));

  a_r3_full_orb: assert property (@(posedge clk) disable iff (!rstN)
    $rose(orbReady) |-> (beats == 8'(ORB_QUADS)));

  a_r3_agent_range: assert property (@(posedge clk) disable iff (!rstN)
    orbReady |-> (int'(orbAgent) < NUM_AGENTS));

  a_r4_single_flight: assert property (@(posedge clk) disable iff (!rstN)
    !(rdReqValid && orbReady));

  a_r4_show_held: assert property (@(posedge clk) disable iff (!rstN)
    (orbReady && !orbAck) |=> (orbReady && $stable(orbData) && $stable(orbAgent)));

endmodule

bind orb_fetch_engine orb_fetch_chk #(
  .NUM_AGENTS(NUM_AGENTS),
  .AGENT_W   (AGENT_W),
  .ADDR_W    (ADDR_W),
  .ORB_QUADS (ORB_QUADS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rdReqValid(rdReqValid),
  .rdReqReady(rdReqReady),
  .rdReqAgent(rdReqAgent),
  .rdReqAddr (rdReqAddr),
  .rspValid  (rspValid),
  .rspError  (rspError),
  .orbReady  (orbReady),
  .orbAgent  (orbAgent),
  .orbData   (orbData),
  .orbAck    (orbAck)
);

// File: tb/tb_orb_fetch_engine.sv
module tb_orb_fetch_engine;

  localparam int NAG = 5;
  localparam int AW  = 3;
  localparam int ADW = 48;
  localparam int NQ  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ptrWrValid = 1'b0;
  logic [AW-1:0] ptrWrAgent = '0;
  logic [ADW-1:0] ptrWrAddr = '0;
  logic [NAG-1:0] agentRst = '0;
  logic rdReqValid;
  logic rdReqReady = 1'b0;
  logic [AW-1:0] rdReqAgent;
  logic [ADW-1:0] rdReqAddr;
  logic [15:0] rdReqBytes;
  logic rspValid = 1'b0;
  logic rspError = 1'b0;
  logic [31:0] rspData = '0;
  logic orbReady;
  logic [AW-1:0] orbAgent;
  logic [NQ*32-1:0] orbData;
  logic orbAck = 1'b0;

  int nTests = 0;
  int nFail  = 0;

  always #4 clk = ~clk;

  orb_fetch_engine dut (
    .clk(clk), .rstN(rstN),
    .ptrWrValid(ptrWrValid), .ptrWrAgent(ptrWrAgent), .ptrWrAddr(ptrWrAddr),
    .agentRst(agentRst),
    .rdReqValid(rdReqValid), .rdReqReady(rdReqReady), .rdReqAgent(rdReqAgent),
    .rdReqAddr(rdReqAddr), .rdReqBytes(rdReqBytes),
    .rspValid(rspValid), .rspError(rspError), .rspData(rspData),
    .orbReady(orbReady), .orbAgent(orbAgent), .orbData(orbData), .orbAck(orbAck)
  );

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // initiator memory: quadlet i of the ORB stored at addr
  function automatic logic [31:0] memWord(input logic [ADW-1:0] addr, input int i,
                                          input bit nul, input logic [ADW-1:0] nxt);
    if (i == 0)      return {nul, 15'h0, nxt[47:32]};
    else if (i == 1) return nxt[31:0];
    else             return addr[31:0] + 32'(i) * 32'h1111_1111;
  endfunction

  task automatic wrPtr(input int ag, input logic [ADW-1:0] a);
    ptrWrValid = 1'b1; ptrWrAgent = AW'(ag); ptrWrAddr = a;
    @(negedge clk);
    ptrWrValid = 1'b0;
  endtask

  task automatic quiet(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rdReqValid) seen = 1'b1;
    end
    chk(!seen, req, 256'(seen), 256'(0));
  endtask

  // accept one request and return a full ORB (or an error beat)
  task automatic fetch(input int ag, input logic [ADW-1:0] a, input bit nul,
                       input logic [ADW-1:0] nxt, input bit err, input string req);
    bit got = 1'b0;
    logic [NQ*32-1:0] expData;
    for (int i = 0; i < 200 && !got; i++) begin
      if (rdReqValid) got = 1'b1;
      else @(negedge clk);
    end
    chk(got, {req, " request issued"}, 256'(got), 256'(1));
    chk(rdReqAgent == AW'(ag), {req, " request agent"}, 256'(rdReqAgent), 256'(ag));
    chk(rdReqAddr == a, {req, " request address"}, 256'(rdReqAddr), 256'(a));
    chk(rdReqBytes == 16'd32, "R2 request length", 256'(rdReqBytes), 256'(32));
    rdReqReady = 1'b1;
    @(negedge clk);
    rdReqReady = 1'b0;
    if (err) begin
      rspValid = 1'b1; rspError = 1'b1;
      @(negedge clk);
      rspValid = 1'b0; rspError = 1'b0;
      @(negedge clk);
      chk(!orbReady, "R9 no ORB after error", 256'(orbReady), 256'(0));
      return;
    end
    for (int i = 0; i < NQ; i++) begin
      rspValid = 1'b1;
      rspData  = memWord(a, i, nul, nxt);
      expData[32*i +: 32] = rspData;
      if (i == NQ - 1) chk(!orbReady, "R3 not ready before last quadlet", 256'(orbReady), 256'(0));
      @(negedge clk);
    end
    rspValid = 1'b0;
    chk(orbReady, "R3 ready after last quadlet", 256'(orbReady), 256'(1));
    chk(orbAgent == AW'(ag), "R3 ORB agent", 256'(orbAgent), 256'(ag));
    chk(orbData == expData, "R3 ORB data", 256'(orbData), 256'(expData));
  endtask

  task automatic ackOrb();
    bit bad = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (!orbReady || rdReqValid) bad = 1'b1;
    end
    chk(!bad, "R4 ORB held, no request before ack (R5)", 256'(bad), 256'(0));
    orbAck = 1'b1;
    @(negedge clk);
    orbAck = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [ADW-1:0] base;
    repeat (3) @(negedge clk);
    chk(!rdReqValid && !orbReady, "R1 reset outputs", 256'({rdReqValid, orbReady}), 256'(0));
    rstN = 1'b1;
    quiet(5, "R1 idle after reset");

    // sweep: every command agent, chains of length 1..3
    for (int ag = 1; ag < NAG; ag++) begin
      for (int len = 1; len <= 3; len++) begin
        base = 48'h0A00_0000_0000 + (48'(ag) << 16) + (48'(len) << 8);
        wrPtr(ag, base);
        for (int j = 0; j < len; j++) begin
          fetch(ag, base + 48'(j) * 48'h40, (j == len - 1), base + 48'(j + 1) * 48'h40, 1'b0,
                (j == 0) ? "R2" : "R5");
          ackOrb();
        end
        quiet(8, "R6 chain stops on null flag");
      end
    end
    wrPtr(1, 48'h0B00_0000_1000);
    fetch(1, 48'h0B00_0000_1000, 1'b1, 48'h0, 1'b0, "R6 new pointer accepted");
    ackOrb();

    // management agent ignores a non-null link
    wrPtr(0, 48'h0C00_1234_0000);
    fetch(0, 48'h0C00_1234_0000, 1'b0, 48'h0C00_5555_0000, 1'b0, "R7");
    ackOrb();
    quiet(10, "R7 management does not chain");

    // writes to pending / busy agents are dropped
    wrPtr(1, 48'h0D00_0000_0100);
    fetch(1, 48'h0D00_0000_0100, 1'b1, 48'h0, 1'b0, "R10");
    wrPtr(2, 48'h0D00_0000_0200);
    wrPtr(2, 48'h0D00_0000_0BAD);
    wrPtr(1, 48'h0D00_0000_0DEF);
    ackOrb();
    fetch(2, 48'h0D00_0000_0200, 1'b1, 48'h0, 1'b0, "R10 pending write ignored");
    ackOrb();
    quiet(6, "R10 busy write ignored");
    wrPtr(1, 48'h0D00_0000_0300);
    fetch(1, 48'h0D00_0000_0300, 1'b1, 48'h0, 1'b0, "R10 agent idle again");
    ackOrb();

    // round robin: after grant 3, order 4,1,2
    wrPtr(3, 48'h0E00_0000_0300);
    wrPtr(1, 48'h0E00_0000_0100);
    wrPtr(4, 48'h0E00_0000_0400);
    wrPtr(2, 48'h0E00_0000_0200);
    fetch(3, 48'h0E00_0000_0300, 1'b1, 48'h0, 1'b0, "R8 first grant");
    ackOrb();
    fetch(4, 48'h0E00_0000_0400, 1'b1, 48'h0, 1'b0, "R8 second grant");
    ackOrb();
    fetch(1, 48'h0E00_0000_0100, 1'b1, 48'h0, 1'b0, "R8 third grant");
    ackOrb();
    fetch(2, 48'h0E00_0000_0200, 1'b1, 48'h0, 1'b0, "R8 fourth grant");
    ackOrb();

    // error response kills one agent only
    wrPtr(3, 48'h0F00_0000_0300);
    fetch(3, 48'h0F00_0000_0300, 1'b0, 48'h0, 1'b1, "R9 errored fetch");
    wrPtr(3, 48'h0F00_0000_0333);
    quiet(12, "R9 dead agent ignores writes");
    wrPtr(2, 48'h0F00_0000_0200);
    fetch(2, 48'h0F00_0000_0200, 1'b1, 48'h0, 1'b0, "R9 other agent unaffected");
    ackOrb();
    agentRst = NAG'(1) << 3;
    @(negedge clk);
    agentRst = '0;
    wrPtr(3, 48'h0F00_0000_0399);
    fetch(3, 48'h0F00_0000_0399, 1'b1, 48'h0, 1'b0, "R9 revived after reset");
    ackOrb();

    // out-of-range agent index
    wrPtr(6, 48'h0F00_0000_0600);
    quiet(10, "R11 bad agent index ignored");
    wrPtr(7, 48'h0F00_0000_0700);
    quiet(10, "R11 bad agent index ignored");

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule